// File: doc/BRIEF.md
# Masked Local-Bus Interrupt Controller

This block gathers sixteen level-sensitive interrupt request lines into one interrupt line for a processor. Each request line is brought into the clock domain through two flip-flops, and the second flop is the source register, so each bit follows the level of its line. A mask register that software can read and write decides which sources may assert the combined output. The output is the OR of all enabled sources. It is registered and changes one clock after the source register or the mask changes.

Software reaches the block through a small register bus that decodes a 12-bit offset, which gives a 4 KB window. Offset 0x02 holds the mask. Offset 0x00 is read-only. It does not return the raw pending bits. It returns the position of the lowest-numbered source that is both pending and enabled, shifted left by two after adding one. The lowest bit index always wins. At reset the mask comes up with only bit 4 set.

Top module: `irq_aggregator`

## Requirements
- R1: During and after reset `irq_out` is 0, the mask reads back 0x0010 and the pending register reads back 0.
- R2: Each request line sets its source bit while it is high and clears it while it is low.
- R3: `irq_out` is 1 exactly when at least one bit is set in both the source register and the mask.
- R4: A change on a request line line reaches `irq_out` at the third rising clock edge after it is applied. A mask write reaches `irq_out` at the rising edge after the edge that stores the mask.
- R5: A read of offset 0x000 returns (n+1)*4, where n is the lowest index that is both set in the source register and enabled in the mask. It returns 0 when no source is pending and enabled.
- R6: Offset 0x002 holds the 16-bit mask. A write stores `bus_wdata` and a read returns the stored value.
- R7: A read request is accepted on a clock edge while `bus_valid` is 1 and `bus_we` is 0. At that same edge `bus_rvalid` rises for exactly one cycle, with the read data on `bus_rdata`. `bus_rvalid` stays 0 for every other cycle.
- R8: A write to any offset other than 0x002, including the read-only offset 0x000, changes no state.
- R9: A read of any offset other than 0x000 or 0x002 returns 0, and `bus_err` is 1 for that one response cycle. Reads of the two valid offsets leave `bus_err` at 0.
- R10: When a mask write and a change of the source register land on the same clock edge, the next value of `irq_out` reflects both the new mask and the new sources.
- R11: Order among pending sources depends only on bit index. A lower-numbered source that is masked off does not hide a higher-numbered source that is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 16 | Level-sensitive interrupt request lines |
| bus_valid | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Register offset inside the 4 KB window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| bus_err | output | 1 | One-cycle pulse on a read of an undefined offset |
| irq_out | output | 1 | Combined interrupt output, registered |

## Verification
A mask write and an update of the source register can take effect on the same clock edge. The bench provokes this by raising or lowering a request line exactly one cycle before it issues a mask write, so that the second synchronizer stage and the mask register load on the same edge. In one case the new mask enables only the bit that has just risen, and in another it enables only the bit that has just dropped. The bench judges the result by checking that `irq_out` keeps its old value in the cycle right after that edge and then settles to the OR of the new sources under the new mask.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int                  N_SRC    = 16,
  parameter int                  AW       = 12,
  parameter int                  DW       = 16,
  parameter logic [AW-1:0]       PEND_OFS = 12'h000,
  parameter logic [AW-1:0]       MASK_OFS = 12'h002,
  parameter logic [N_SRC-1:0]    MASK_RST = 16'h0010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic             bus_valid,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             bus_rvalid,
  output logic             bus_err,
  output logic             irq_out
);

  logic [N_SRC-1:0] sync_q;
  logic [N_SRC-1:0] src_q;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] pend;
  logic [DW-1:0]    enc;
  logic             rd_req, wr_mask, hit_pend, hit_mask;

  assign pend     = src_q & mask_q;
  assign rd_req   = bus_valid && !bus_we;
  assign hit_pend = (bus_addr == PEND_OFS);
  assign hit_mask = (bus_addr == MASK_OFS);
  assign wr_mask  = bus_valid && bus_we && hit_mask;

  always_comb begin
    enc = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (pend[i]) enc = DW'((i + 1) << 2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      src_q  <= '0;
    end else begin
      sync_q <= irq_in;
      src_q  <= sync_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= MASK_RST;
    else if (wr_mask) mask_q <= bus_wdata[N_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= |pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      bus_rvalid <= rd_req;
      bus_err    <= rd_req && !hit_pend && !hit_mask;
      if (rd_req)
        bus_rdata <= hit_pend ? enc : hit_mask ? DW'(mask_q) : '0;
    end
  end

endmodule

module irq_aggregator_chk #(
  parameter int            N_SRC    = 16,
  parameter int            AW       = 12,
  parameter int            DW       = 16,
  parameter logic [AW-1:0] PEND_OFS = 12'h000,
  parameter logic [AW-1:0] MASK_OFS = 12'h002
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_rdata,
  input logic             bus_rvalid,
  input logic             bus_err,
  input logic [N_SRC-1:0] mask_q
);

  // R7
  rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we) |=> bus_rvalid);

  // R7
  rvalid_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_we) |=> !bus_rvalid);

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we && bus_addr != PEND_OFS && bus_addr != MASK_OFS) |=> (bus_err && bus_rdata == '0));

  // R9
  err_only_bad_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_we && bus_addr != PEND_OFS && bus_addr != MASK_OFS) |=> !bus_err);

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_we && bus_addr == MASK_OFS) |=> $stable(mask_q));

  // R5
  enc_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we && bus_addr == PEND_OFS) |=>
      (bus_rdata[1:0] == 2'b00 && bus_rdata <= DW'(N_SRC << 2)));

endmodule

bind irq_aggregator irq_aggregator_chk #(
  .N_SRC(N_SRC), .AW(AW), .DW(DW), .PEND_OFS(PEND_OFS), .MASK_OFS(MASK_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .bus_err(bus_err), .mask_q(mask_q)
);

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/1ps
module irq_aggregator_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid, bus_err, irq_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [15:0] rd_v;
  logic        rd_ok, rd_err;

  always #10 clk = ~clk;

  irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .bus_err(bus_err), .irq_out(irq_out)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [15:0] d);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    rd_v = bus_rdata; rd_ok = bus_rvalid; rd_err = bus_err;
    bus_valid = 1'b0;
  endtask

  task automatic set_lines(input logic [15:0] v);
    irq_in = v;
    step(3);
  endtask

  task automatic t_reset;
    chk("R1 irq_out in reset", irq_out, 0);
    chk("R7 rvalid in reset", bus_rvalid, 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 irq_out after reset", irq_out, 0);
    bus_read(12'h002);
    chk("R1 mask reset value", rd_v, 16'h0010);
    chk("R7 rvalid on read", rd_ok, 1);
    step(1);
    chk("R7 rvalid one cycle", bus_rvalid, 0);
    bus_read(12'h000);
    chk("R1 pending after reset", rd_v, 0);
    set_lines(16'h0010);
    chk("R3 bit4 enabled by reset mask", irq_out, 1);
    bus_read(12'h000);
    chk("R5 bit4 encoded", rd_v, 20);
    set_lines(16'h0008);
    chk("R3 bit3 masked by reset mask", irq_out, 0);
    set_lines(16'h0000);
  endtask

  task automatic t_level;
    bus_write(12'h002, 16'hFFFF);
    set_lines(16'h0080);
    bus_read(12'h000);
    chk("R2 line7 high sets source", rd_v, 32);
    chk("R3 irq_out on pending", irq_out, 1);
    set_lines(16'h0000);
    bus_read(12'h000);
    chk("R2 line7 low clears source", rd_v, 0);
    chk("R3 irq_out idle", irq_out, 0);
  endtask

  task automatic t_latency;
    irq_in = 16'h0004;
    step(2);
    chk("R4 irq_out not yet after two edges", irq_out, 0);
    step(1);
    chk("R4 irq_out at third edge", irq_out, 1);
    bus_write(12'h002, 16'h0000);
    chk("R4 irq_out holds on mask store edge", irq_out, 1);
    step(1);
    chk("R4 irq_out follows mask one edge later", irq_out, 0);
    irq_in = 16'h0000;
    step(3);
  endtask

  task automatic t_mask_rw;
    bus_write(12'h002, 16'hA5C3);
    bus_read(12'h002);
    chk("R6 mask readback A5C3", rd_v, 16'hA5C3);
    chk("R9 no err on mask read", rd_err, 0);
    bus_write(12'h002, 16'h5A3C);
    bus_read(12'h002);
    chk("R6 mask readback 5A3C", rd_v, 16'h5A3C);
  endtask

  task automatic t_priority;
    bus_write(12'h002, 16'hFFFF);
    set_lines(16'h0242);
    bus_read(12'h000);
    chk("R5 lowest of 1,6,9", rd_v, 8);
    chk("R9 no err on pending read", rd_err, 0);
    bus_write(12'h002, 16'hFFFD);
    bus_read(12'h000);
    chk("R11 masked bit1 skips to 6", rd_v, 28);
    bus_write(12'h002, 16'h0200);
    bus_read(12'h000);
    chk("R11 only bit9 enabled", rd_v, 40);
    bus_write(12'h002, 16'h0000);
    step(1);
    bus_read(12'h000);
    chk("R5 nothing enabled reads 0", rd_v, 0);
    chk("R3 irq_out low with sources masked", irq_out, 0);
    bus_write(12'h002, 16'hFFFF);
    set_lines(16'h8000);
    bus_read(12'h000);
    chk("R5 bit15 encoded", rd_v, 64);
    set_lines(16'h8001);
    bus_read(12'h000);
    chk("R5 bit0 encoded", rd_v, 4);
    set_lines(16'h0000);
  endtask

  task automatic t_invalid;
    bus_write(12'h002, 16'h1234);
    bus_write(12'h000, 16'hFFFF);
    bus_write(12'h006, 16'h0000);
    bus_write(12'hFFE, 16'h0000);
    bus_read(12'h002);
    chk("R8 writes elsewhere ignored", rd_v, 16'h1234);
    bus_read(12'h004);
    chk("R9 bad read data", rd_v, 0);
    chk("R9 bad read err", rd_err, 1);
    chk("R7 rvalid on bad read", rd_ok, 1);
    step(1);
    chk("R9 err one cycle", bus_err, 0);
    bus_read(12'hFFE);
    chk("R9 bad read top of window", rd_err, 1);
    step(1);
  endtask

  task automatic t_concurrent;
    bus_write(12'h002, 16'h0000);
    set_lines(16'h0000);
    irq_in = 16'h0008;
    step(1);
    bus_write(12'h002, 16'h0008);
    chk("R10 old output kept on shared edge", irq_out, 0);
    step(1);
    chk("R10 rise with new mask and source", irq_out, 1);
    irq_in = 16'h0020;
    step(1);
    bus_write(12'h002, 16'h0020);
    step(1);
    chk("R10 moved source and mask together", irq_out, 1);
    irq_in = 16'h0000;
    step(1);
    bus_write(12'h002, 16'h0020);
    step(1);
    chk("R10 dropped source under same mask", irq_out, 0);
    irq_in = 16'h0001;
    step(1);
    bus_write(12'h002, 16'hFFFE);
    step(1);
    chk("R10 new source masked by new mask", irq_out, 0);
    irq_in = 16'h0000;
    step(3);
  endtask

  initial begin
    step(3);
    t_reset();
    t_level();
    t_latency();
    t_mask_rw();
    t_priority();
    t_invalid();
    t_concurrent();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule